// File: doc/BRIEF.md
# Sound Coprocessor Window Arbiter

This block sits between a main processor and the 64 KB address space of a sound coprocessor. Each access that arrives through the window is decoded into one of four targets: an 8 KB shared byte RAM (addressed by the low 13 bits, so it repeats across the window), the four register ports of an FM synthesizer, the write-only port of a programmable sound generator, and a 9-bit bank register. The bank register is filled serially. Each write shifts it one place toward bit 0 and inserts a new bit at the top. The register then names a 32 KB page of main memory.

The block also holds the two coprocessor control bits: bus request and reset. Each is written with the inverse of the data bit presented. A status bit reads back whether the coprocessor still owns its bus or is held in reset. Window accesses are granted only when the coprocessor has given up its bus and is out of reset. In any other state, writes are dropped and reads return the open-bus byte supplied by the surroundings. A granted access costs one extra wait cycle. The RAM and sound chips are outside the block and are reached through strobes.

Top module: `snd_window_arb`

## Requirements
- R1: After reset the coprocessor owns its bus (`coproc_run`=1) and is held in reset (`coproc_in_reset`=1). `bus_stat` is 1, `bank_base` is 0, and `ack`, `dec_err` and all strobes are 0.
- R2: A control write with `ctl_sel`=0 sets `coproc_run` to the inverse of the selected data bit. With `ctl_sel`=1 it sets `coproc_in_reset` the same way. The selected bit is `ctl_wdata[0]` for byte writes and `ctl_wdata[8]` for word writes (`ctl_word`=1). The change is visible after the next clock edge. `bus_stat` equals `coproc_run` OR `coproc_in_reset`.
- R3: A granted access with address bit 14 clear targets the RAM. `ram_addr` is address bits 12:0, which mirrors the RAM; bits 13 and 15 are ignored. Writes pulse `ram_we` and reads pulse `ram_rd`.
- R4: A granted access in the range 0x4000 to 0x5FFF targets the FM chip. `fm_sel` is address bits 1:0. Writes pulse `fm_wr` and reads pulse `fm_rd`.
- R5: A granted write whose address bits 14:8 are 0x7F and whose bits 7:0 are 0x11, 0x13, 0x15 or 0x17 pulses `psg_wr`.
- R6: A granted write whose address bits 14:8 equal 0x60 shifts the bank register right by one and loads the write byte's bit 0 into bit 8. `bank_base` is the bank register times 32768.
- R7: Access is blocked while `bus_stat` is 1. A blocked write drives no strobe, does not raise `dec_err` and leaves the bank unchanged. A blocked read returns `float_byte`.
- R8: A request is taken on a clock edge where `req_valid` is 1 and no access is in flight. A granted request drives its strobe in the following cycle and `ack` in the cycle after that. A blocked request drives `ack` in the following cycle. `req_valid` is ignored while an access is in flight.
- R9: A byte read returns {0x00, byte}. A word read returns the byte in both halves. The byte written is `req_wdata[7:0]` for byte writes and `req_wdata[15:8]` for word writes; `snd_wdata` carries it during the strobe cycle.
- R10: A granted write that matches no target drives no strobe and raises `dec_err` for exactly one cycle, the strobe cycle. A granted read outside the RAM and FM ranges returns `float_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Window access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_addr | input | 16 | Offset inside the window |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | Access complete (one-cycle pulse) |
| rdata | output | 16 | Read result, valid with `ack` |
| float_byte | input | 8 | Open-bus value for blocked or unmapped reads |
| ctl_wr | input | 1 | Control bit write strobe |
| ctl_sel | input | 1 | 0 = bus request bit, 1 = reset bit |
| ctl_word | input | 1 | Control write is a word write |
| ctl_wdata | input | 16 | Control write data |
| coproc_run | output | 1 | Coprocessor owns its bus |
| coproc_in_reset | output | 1 | Coprocessor held in reset |
| bus_stat | output | 1 | Status readback: run OR reset |
| ram_addr | output | 13 | Shared RAM byte index |
| ram_we | output | 1 | RAM write strobe |
| ram_rd | output | 1 | RAM read strobe |
| ram_rdata | input | 8 | RAM read data |
| fm_sel | output | 2 | FM register port select |
| fm_wr | output | 1 | FM write strobe |
| fm_rd | output | 1 | FM read strobe |
| fm_rdata | input | 8 | FM read data |
| psg_wr | output | 1 | Sound generator write strobe |
| snd_wdata | output | 8 | Byte written to RAM, FM or sound generator |
| bank_base | output | 24 | Selected 32 KB page base in main memory |
| dec_err | output | 1 | Unmatched granted write |

## Verification
The embedded properties check on every cycle that at most one strobe fires, that a blocked request produces only an acknowledge one cycle later, and that a granted one produces an acknowledge two cycles later. They also check that the error flag never lasts longer than a cycle, that the bank only moves on a shift, and that the control bits change only on a control write. The mirrored RAM indexing, the exact PSG and bank address matches, the byte lane chosen for word writes and the doubled word read are shown only by the bench's scenarios. The same holds for the bank register's value after a run of serial writes and for the rule that a request made mid-access is ignored. The bench compares these against its own address model.

// File: rtl/snd_win_pkg.sv
package snd_win_pkg;

    typedef enum logic [2:0] {
        TGT_RAM  = 3'd0,
        TGT_FM   = 3'd1,
        TGT_PSG  = 3'd2,
        TGT_BANK = 3'd3,
        TGT_NONE = 3'd4
    } tgt_e;

    typedef struct packed {
        logic        busy;
        logic        ack;
        logic        err;
        logic        is_rd;
        logic        is_word;
        tgt_e        tgt;
        logic [12:0] idx;
        logic [1:0]  fsel;
        logic [7:0]  wbyte;
        logic [15:0] rdata;
    } win_st_t;

    // place a read byte on the return lanes
    function automatic logic [15:0] rd_pack(input logic [7:0] b, input logic word);
        return word ? {b, b} : {8'h00, b};
    endfunction

endpackage

// File: rtl/snd_win_decode.sv
module snd_win_decode
    import snd_win_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    output tgt_e              tgt
);
    logic unused_hi;
    assign unused_hi = ^addr[ADDR_W-1:15];

    always_comb begin
        if (!addr[14])
            tgt = TGT_RAM;                                   // R3
        else if ((addr[14:0] & 15'h6000) == 15'h4000)
            tgt = TGT_FM;                                    // R4
        else if (is_write && ((addr[14:0] & 15'h7FF9) == 15'h7F11))
            tgt = TGT_PSG;                                   // R5
        else if (is_write && ((addr[14:0] & 15'h7F00) == 15'h6000))
            tgt = TGT_BANK;                                  // R6
        else
            tgt = TGT_NONE;
    end
endmodule

// File: rtl/snd_win_bank.sv
module snd_win_bank #(
    parameter int BANK_W  = 9,
    parameter int PAGE_SH = 15,
    localparam int BASE_W = BANK_W + PAGE_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [BASE_W-1:0] base
);
    logic [BANK_W-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (shift_en)
            bank_d = {bit_in, bank_q[BANK_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign base = {bank_q, {PAGE_SH{1'b0}}};

    a_r6_shift_in_top: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (bank_q[BANK_W-1] == $past(bit_in)) &&
                     (bank_q[BANK_W-2:0] == $past(bank_q[BANK_W-1:1])));
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(bank_q));
endmodule

// File: rtl/snd_win_ctl.sv
module snd_win_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic sel,
    input  logic bit_val,
    output logic run,
    output logic in_reset
);
    logic run_d, run_q, rst_d, rst_q;

    always_comb begin
        run_d = run_q;
        rst_d = rst_q;
        if (wr && !sel) run_d = ~bit_val;
        if (wr &&  sel) rst_d = ~bit_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b1;
            rst_q <= 1'b1;
        end else begin
            run_q <= run_d;
            rst_q <= rst_d;
        end
    end

    assign run      = run_q;
    assign in_reset = rst_q;

    a_r2_stable_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable({run_q, rst_q}));
    a_r2_other_bit_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !sel) |=> $stable(rst_q));
endmodule

// File: rtl/snd_window_arb.sv
module snd_window_arb
    import snd_win_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int RAM_AW  = 13,
    parameter int BANK_W  = 9,
    parameter int PAGE_SH = 15,
    localparam int BASE_W = BANK_W + PAGE_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    output logic              ack,
    output logic [15:0]       rdata,
    input  logic [7:0]        float_byte,
    input  logic              ctl_wr,
    input  logic              ctl_sel,
    input  logic              ctl_word,
    input  logic [15:0]       ctl_wdata,
    output logic              coproc_run,
    output logic              coproc_in_reset,
    output logic              bus_stat,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we,
    output logic              ram_rd,
    input  logic [7:0]        ram_rdata,
    output logic [1:0]        fm_sel,
    output logic              fm_wr,
    output logic              fm_rd,
    input  logic [7:0]        fm_rdata,
    output logic              psg_wr,
    output logic [7:0]        snd_wdata,
    output logic [BASE_W-1:0] bank_base,
    output logic              dec_err
);
    win_st_t st_d, st_q;
    tgt_e    dec_tgt;
    logic    blocked, take, shift_en;
    logic [7:0] wbyte_in, src_byte;

    logic unused_ctl;
    assign unused_ctl = ^{ctl_wdata[15:9], ctl_wdata[7:1]};

    snd_win_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(req_addr), .is_write(req_write), .tgt(dec_tgt)
    );

    snd_win_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .sel(ctl_sel),
        .bit_val(ctl_word ? ctl_wdata[8] : ctl_wdata[0]),
        .run(coproc_run), .in_reset(coproc_in_reset)
    );

    assign blocked  = coproc_run | coproc_in_reset;
    assign bus_stat = blocked;
    assign take     = req_valid && !st_q.busy;
    assign wbyte_in = req_word ? req_wdata[15:8] : req_wdata[7:0];   // R9
    assign shift_en = take && !blocked && req_write && (dec_tgt == TGT_BANK);

    snd_win_bank #(.BANK_W(BANK_W), .PAGE_SH(PAGE_SH)) u_bank (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
        .bit_in(wbyte_in[0]), .base(bank_base)
    );

    always_comb begin
        case (st_q.tgt)
            TGT_RAM: src_byte = ram_rdata;
            TGT_FM:  src_byte = fm_rdata;
            default: src_byte = float_byte;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        st_d.err = 1'b0;
        if (st_q.busy) begin
            st_d.busy  = 1'b0;
            st_d.ack   = 1'b1;
            st_d.rdata = st_q.is_rd ? rd_pack(src_byte, st_q.is_word) : 16'h0000;
        end else if (req_valid) begin
            st_d.is_rd   = !req_write;
            st_d.is_word = req_word;
            st_d.idx     = req_addr[RAM_AW-1:0];
            st_d.fsel    = req_addr[1:0];
            st_d.wbyte   = wbyte_in;
            if (blocked) begin
                st_d.ack   = 1'b1;
                st_d.tgt   = TGT_NONE;
                st_d.rdata = req_write ? 16'h0000 : rd_pack(float_byte, req_word);
            end else begin
                st_d.busy = 1'b1;
                st_d.tgt  = dec_tgt;
                st_d.err  = req_write && (dec_tgt == TGT_NONE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.tgt     <= TGT_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack       = st_q.ack;
    assign rdata     = st_q.rdata;
    assign dec_err   = st_q.err;
    assign ram_addr  = st_q.idx;
    assign fm_sel    = st_q.fsel;
    assign snd_wdata = st_q.wbyte;
    assign ram_we    = st_q.busy && !st_q.is_rd && (st_q.tgt == TGT_RAM);
    assign ram_rd    = st_q.busy &&  st_q.is_rd && (st_q.tgt == TGT_RAM);
    assign fm_wr     = st_q.busy && !st_q.is_rd && (st_q.tgt == TGT_FM);
    assign fm_rd     = st_q.busy &&  st_q.is_rd && (st_q.tgt == TGT_FM);
    assign psg_wr    = st_q.busy && !st_q.is_rd && (st_q.tgt == TGT_PSG);

    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_we, ram_rd, fm_wr, fm_rd, psg_wr}));
    a_r7_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (take && blocked) |=> ack && !dec_err && !(ram_we || ram_rd || fm_wr || fm_rd || psg_wr));
    a_r8_grant_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !blocked) |=> !ack ##1 ack);
    a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |=> !dec_err);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !ack && !dec_err && !ram_we && !fm_wr && !psg_wr);
endmodule

// File: tb/snd_window_arb_tb_top.sv
module snd_window_arb_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_word = 0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic ack; logic [15:0] rdata;
    logic [7:0] float_byte = 8'h5A;
    logic ctl_wr = 0, ctl_sel = 0, ctl_word = 0;
    logic [15:0] ctl_wdata = '0;
    logic coproc_run, coproc_in_reset, bus_stat;
    logic [12:0] ram_addr; logic ram_we, ram_rd;
    logic [7:0] ram_rdata;
    logic [1:0] fm_sel; logic fm_wr, fm_rd;
    logic [7:0] fm_rdata;
    logic psg_wr; logic [7:0] snd_wdata;
    logic [23:0] bank_base; logic dec_err;

    int n_cmp = 0, n_bad = 0;
    bit m_run = 1, m_rst = 1;
    logic [8:0] m_bank = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // peripheral models: data is a function of the index, no storage
    assign ram_rdata = ram_addr[7:0] ^ {3'b000, ram_addr[12:8]} ^ 8'h3C;
    assign fm_rdata  = 8'hC0 | {6'd0, fm_sel};

    snd_window_arb dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // 0 ram 1 fm 2 psg 3 bank 4 none
    function automatic int exp_tgt(input logic [15:0] a, input bit wr);
        if (a[14] == 1'b0) return 0;
        if (a[13] == 1'b0) return 1;
        if (wr && a[14:8] == 7'h7F && a[7:3] == 5'b00010 && a[0]) return 2;
        if (wr && a[14:8] == 7'h60) return 3;
        return 4;
    endfunction

    function automatic logic [7:0] exp_rbyte(input logic [15:0] a, input logic [7:0] fl);
        case (exp_tgt(a, 0))
            0: return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h3C;
            1: return 8'hC0 | {6'd0, a[1:0]};
            default: return fl;
        endcase
    endfunction

    function automatic logic [15:0] lanes(input logic [7:0] b, input bit w);
        return w ? {b, b} : {8'h00, b};
    endfunction

    task automatic ctl_write(input bit sel, input bit word, input logic [15:0] d);
        bit b;
        @(negedge clk);
        ctl_wr = 1; ctl_sel = sel; ctl_word = word; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 0;
        b = word ? d[8] : d[0];
        if (sel) m_rst = !b; else m_run = !b;
        chk("R2 run", coproc_run, m_run);
        chk("R2 reset", coproc_in_reset, m_rst);
        chk("R2 status", bus_stat, m_run | m_rst);
    endtask

    task automatic access(input bit wr, input bit word, input logic [15:0] a,
                          input logic [15:0] d, input logic [7:0] fl);
        bit blk; int t; logic [7:0] wb;
        blk = m_run | m_rst;
        t   = exp_tgt(a, wr);
        wb  = word ? d[15:8] : d[7:0];
        @(negedge clk);
        req_valid = 1; req_write = wr; req_word = word; req_addr = a;
        req_wdata = d; float_byte = fl;
        @(negedge clk);
        req_valid = 0;
        if (blk) begin
            chk("R7 blocked ack", ack, 1);
            chk("R7 blocked strobes", {ram_we, ram_rd, fm_wr, fm_rd, psg_wr, dec_err}, 0);
            chk("R7 blocked bank", bank_base, {m_bank, 15'd0});
            if (!wr) chk("R7 float read", rdata, lanes(fl, word));
        end else begin
            if (wr && t == 3) m_bank = {wb[0], m_bank[8:1]};
            chk("R8 wait cycle", ack, 0);
            chk("R3 ram_we", ram_we, wr && t == 0);
            chk("R3 ram_rd", ram_rd, !wr && t == 0);
            chk("R4 fm_wr", fm_wr, wr && t == 1);
            chk("R4 fm_rd", fm_rd, !wr && t == 1);
            chk("R5 psg_wr", psg_wr, wr && t == 2);
            chk("R10 dec_err", dec_err, wr && t == 4);
            chk("R6 bank", bank_base, {m_bank, 15'd0});
            if (t == 0) chk("R3 ram_addr", ram_addr, a[12:0]);
            if (t == 1) chk("R4 fm_sel", fm_sel, a[1:0]);
            if (wr && t <= 2) chk("R9 write byte", snd_wdata, wb);
            @(negedge clk);
            chk("R8 ack", ack, 1);
            chk("R10 err pulse", dec_err, 0);
            if (!wr) chk("R9 read lanes", rdata, lanes(exp_rbyte(a, fl), word));
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 run", coproc_run, 1);
        chk("R1 reset", coproc_in_reset, 1);
        chk("R1 status", bus_stat, 1);
        chk("R1 bank", bank_base, 0);
        chk("R1 outputs", {ack, dec_err, ram_we, ram_rd, fm_wr, fm_rd, psg_wr}, 0);

        // R7 blocked accesses
        access(1, 0, 16'h0123, 16'h0077, 8'h11);
        access(1, 0, 16'h6000, 16'h0001, 8'h22);
        access(0, 1, 16'h0040, 16'h0000, 8'hA5);
        access(0, 0, 16'h4002, 16'h0000, 8'h96);

        // R2 control bits, byte and word lanes
        ctl_write(1, 0, 16'h0001);          // out of reset
        access(1, 0, 16'h0010, 16'h0044, 8'h33); // still blocked by run
        ctl_write(0, 1, 16'h00FF);          // word: bit8=0 -> run stays 1
        ctl_write(0, 1, 16'h0100);          // word: bit8=1 -> bus released

        // granted directed cases
        access(1, 0, 16'h8123, 16'h00EE, 8'h00);  // R3 mirror via bit 15
        access(1, 0, 16'h2123, 16'h00DD, 8'h00);  // R3 mirror via bit 13
        access(1, 1, 16'h0200, 16'hABCD, 8'h00);  // R9 upper byte
        access(0, 1, 16'h3456, 16'h0000, 8'h00);  // R9 doubled
        access(0, 0, 16'h1001, 16'h0000, 8'h00);
        access(1, 0, 16'h5FFE, 16'h0012, 8'h00);  // R4
        access(0, 1, 16'h4001, 16'h0000, 8'h00);  // R4 read
        access(1, 0, 16'h7F11, 16'h0090, 8'h00);  // R5
        access(1, 1, 16'h7F17, 16'h9F00, 8'h00);  // R5 alias
        access(1, 0, 16'h7F13, 16'h0001, 8'h00);
        access(1, 0, 16'h7F19, 16'h0001, 8'h00);  // R10 no match
        access(1, 0, 16'h7000, 16'h0001, 8'h00);  // R10
        access(0, 0, 16'h6800, 16'h0000, 8'hC3);  // R10 float read
        access(0, 1, 16'h7F11, 16'h0000, 8'h3E);  // PSG not readable
        for (int i = 0; i < 9; i++)               // R6 fill pattern 1_0110_1011
            access(1, 0, 16'h6000 | 16'(i), {15'd0, 1'(9'h16B >> i)}, 8'h00);
        chk("R6 full pattern", bank_base, {9'h16B, 15'd0});
        access(1, 1, 16'h60FE, 16'h0100, 8'h00);  // R6 word uses bit 8

        // R8 request held through busy cycle is ignored
        @(negedge clk);
        req_valid = 1; req_write = 1; req_word = 0; req_addr = 16'h0010; req_wdata = 16'h0055;
        @(negedge clk);
        req_addr = 16'h0020;
        chk("R8 first strobe", ram_we, 1);
        @(negedge clk);
        req_valid = 0;
        chk("R8 ack busy", ack, 1);
        chk("R8 held req ignored", ram_we, 0);
        @(negedge clk);
        chk("R8 no second access", {ack, ram_we}, 0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int r; logic [15:0] a;
            r = $urandom % 16;
            if (r == 0) begin
                ctl_write(1'($urandom), 1'($urandom), 16'($urandom));
            end else if (r == 1) begin
                ctl_write(0, 0, 16'h0001);
                ctl_write(1, 0, 16'h0001);
            end else begin
                case ($urandom % 5)
                    0: a = 16'($urandom);
                    1: a = 16'h4000 | 16'($urandom % 16'h2000);
                    2: a = 16'h7F10 | 16'($urandom % 8);
                    3: a = 16'h6000 | 16'($urandom % 256);
                    default: a = 16'($urandom) & 16'hBFFF;
                endcase
                access(1'($urandom), 1'($urandom), a, 16'($urandom), 8'($urandom));
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule